// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns a bank of up to 32 asynchronous GPIO inputs into one interrupt line for the port. Each input passes through a two-flop synchronizer. A 2-bit trigger code chosen per pin then decides what counts as an event on that pin: an active-high level, an active-low level, a rising edge or a falling edge. An event sets a sticky pending bit for its pin. Pending bits whose mask bit is set raise a port-level flag and, while the port is enabled, the registered interrupt output.

Software reaches the block over a 32-bit register interface with single-cycle write and read strobes. The five registers are: control, pending, mask, and two trigger-code words. The trigger word for the low sixteen pins sits at the higher address. Pending bits and the port flag are cleared by writing 1 to them. The control register also picks how often the inputs are sampled. With the fast setting they are sampled every clock. With the slow setting they are sampled once every `SLOW_DIV` clocks.

Top module: `pinport_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: The trigger code for a pin selects its event: code 0 = input high, code 1 = input low, code 2 = low-to-high change between consecutive samples, code 3 = high-to-low change. An event sets that pin's bit in the pending register at address 0x04.
- R3: Trigger codes are packed 2 bits per pin, with the field at bit (pin mod 16)*2. Pins 0 to 15 use the word at address 0x10 and pins 16 to 31 use the word at 0x0C. Both words read back what was written.
- R4: Writing 1 to a pending bit clears it. An edge-triggered pin stays pending until it is cleared. A level-triggered pin whose level is still active becomes pending again on the next sample.
- R5: The mask register at 0x08 has one bit per pin, and a 1 lets that pin take part. `irq_out` equals, one clock later, control bit 1 ANDed with the OR of (pending AND mask).
- R6: Control register at 0x00: bit 0 is the port flag, bit 1 is the port enable and bit 2 selects fast sampling. The flag is set whenever any pin is both pending and unmasked. Writing 1 to bit 0 clears the flag.
- R7: While the enable (control bit 1) is 0, no pending bit becomes set, whatever the inputs do.
- R8: When an event and a write-1-to-clear reach the same pending bit, or the same port flag, in the same cycle, the bit ends up set.
- R9: `NUM_PINS` sets the pin count (32, 30, 12 and 8 are all legal). Pending, mask and trigger-code bits belonging to absent pins read as zero.
- R10: With control bit 2 set, the inputs are sampled every clock. With it clear, they are sampled once every `SLOW_DIV` clocks, and a held edge is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| pins_in | input | NUM_PINS | Asynchronous GPIO inputs |
| irq_out | output | 1 | Registered port interrupt |

## Verification
Two things can fall in the same cycle: a software clear of a pending bit or of the port flag, and a fresh event that sets it again. The bench provokes this in two ways. It issues a clear while a level-high pin is held active with fast sampling. It also times an input edge so that the synchronized change arrives on exactly the clock that takes the clear write. In both cases the register is read back the clock after, and the bit is expected to be 1. The same collision is applied to the port flag while an unmasked pin stays pending.

// File: rtl/pinport_irq_pkg.sv
package pinport_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_LVL_LO = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;

  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PEND    = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_MASK    = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_TYPE_HI = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_TYPE_LO = 5'h10;

  localparam int CTL_FLAG = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_FAST = 2;
endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_in;
      stab_q <= meta_q;
    end
  end

  assign d_out = stab_q;
endmodule

// File: rtl/pinport_trig_det.sv
module pinport_trig_det
  import pinport_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sample,
  input  logic       arm,
  input  logic       level_in,
  input  logic [1:0] code,
  output logic       evt
);
  logic prev_q;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (sample) prev_q <= level_in;
  end

  always_comb begin
    unique case (trig_e'(code))
      TRIG_LVL_HI: hit = level_in;
      TRIG_LVL_LO: hit = ~level_in;
      TRIG_RISE:   hit = level_in & ~prev_q;
      TRIG_FALL:   hit = ~level_in & prev_q;
      default:     hit = 1'b0;
    endcase
  end

  assign evt = arm & sample & hit;
endmodule

// File: rtl/pinport_irq_ctrl.sv
module pinport_irq_ctrl
  import pinport_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [4:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic                irq_out
);
  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [NUM_PINS-1:0]      sync_pins;
  logic [NUM_PINS-1:0]      evt;
  logic [NUM_PINS-1:0]      pend_q;
  logic [NUM_PINS-1:0]      mask_q;
  logic [NUM_PINS-1:0][1:0] trig_q;
  logic                     en_q;
  logic                     fast_q;
  logic                     flag_q;
  logic                     irq_q;
  logic [DIV_W-1:0]         div_q;
  logic                     sample;
  logic [NUM_PINS-1:0]      pend_clr;
  logic                     any_hit;
  logic [31:0]              type_lo_word;
  logic [31:0]              type_hi_word;

  pinport_sync #(.W(NUM_PINS)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .d_in (pins_in),
    .d_out(sync_pins)
  );

  always_ff @(posedge clk) begin
    if (rst)                 div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign sample = fast_q | (div_q == DIV_LAST);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pinport_trig_det det_i (
      .clk     (clk),
      .rst     (rst),
      .sample  (sample),
      .arm     (en_q),
      .level_in(sync_pins[g]),
      .code    (trig_q[g]),
      .evt     (evt[g])
    );
  end

  assign pend_clr = (wr_en && addr == ADR_PEND) ? wdata[NUM_PINS-1:0] : '0;
  assign any_hit  = |(pend_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      fast_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | evt;
      if (wr_en && addr == ADR_MASK) mask_q <= wdata[NUM_PINS-1:0];
      if (wr_en && addr == ADR_CTRL) begin
        en_q   <= wdata[CTL_EN];
        fast_q <= wdata[CTL_FAST];
      end
      flag_q <= (flag_q & ~(wr_en && addr == ADR_CTRL && wdata[CTL_FLAG])) | any_hit;
      irq_q  <= en_q & any_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (addr == ((i < 16) ? ADR_TYPE_LO : ADR_TYPE_HI))
          trig_q[i] <= wdata[(i % 16) * 2 +: 2];
      end
    end
  end

  always_comb begin
    type_lo_word = '0;
    type_hi_word = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (i < 16) type_lo_word[(i % 16) * 2 +: 2] = trig_q[i];
      else        type_hi_word[(i % 16) * 2 +: 2] = trig_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (addr)
        ADR_CTRL:    rdata <= {29'd0, fast_q, en_q, flag_q};
        ADR_PEND:    rdata <= 32'(pend_q);
        ADR_MASK:    rdata <= 32'(mask_q);
        ADR_TYPE_HI: rdata <= type_hi_word;
        ADR_TYPE_LO: rdata <= type_lo_word;
        default:     rdata <= '0;
      endcase
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/pinport_irq_chk.sv
module pinport_irq_chk
  import pinport_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [4:0]          addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] mask,
  input logic                en,
  input logic                flag
);
  localparam logic [31:0] PIN_MASK =
    (NUM_PINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_PINS) - 32'd1);

  logic [NUM_PINS-1:0] clrv;
  assign clrv = (wr_en && addr == ADR_PEND) ? wdata[NUM_PINS-1:0] : '0;

  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(en && (|(pend & mask))));

  assert_no_set_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((pend & ~$past(pend)) == '0));

  assert_only_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ((($past(pend) & ~$past(clrv)) & ~pend) == '0));

  assert_flag_on_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (|(pend & mask)) |=> flag);

  assert_absent_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADR_PEND || addr == ADR_MASK)) |=> ((rdata & ~PIN_MASK) == '0));
endmodule

bind pinport_irq_ctrl pinport_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .irq_out(irq_out),
  .pend   (pend_q),
  .mask   (mask_q),
  .en     (en_q),
  .flag   (flag_q)
);

// File: tb/pinport_irq_ctrl_tb_top.sv
module pinport_irq_ctrl_tb_top;
  localparam int SLOW_DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rdata;
  logic [31:0] rdata12;
  logic        irq;
  logic        irq12;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinport_irq_ctrl #(.NUM_PINS(32), .SLOW_DIV(SLOW_DIV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins), .irq_out(irq)
  );

  pinport_irq_ctrl #(.NUM_PINS(12), .SLOW_DIV(SLOW_DIV)) dut12_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata12), .pins_in(pins[11:0]), .irq_out(irq12)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic [31:0] d12);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; d12 = rdata12;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_pend(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [31:0] o, input logic [31:0] n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c = (i < 16) ? lo[(i % 16) * 2 +: 2] : hi[(i % 16) * 2 +: 2];
      case (c)
        2'd0: r[i] = o[i] | n[i];
        2'd1: r[i] = ~o[i] | ~n[i];
        2'd2: r[i] = ~o[i] & n[i];
        default: r[i] = o[i] & ~n[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d12, lo, hi, o, n, m, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(5'h00, d, d12); chk("R1 ctrl", d, 0);
    rd(5'h04, d, d12); chk("R1 pend", d, 0);
    rd(5'h08, d, d12); chk("R1 mask", d, 0);
    rd(5'h0C, d, d12); chk("R1 type_hi", d, 0);
    rd(5'h10, d, d12); chk("R1 type_lo", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3: type word readback
    wr(5'h10, 32'hA5A5_1234); rd(5'h10, d, d12); chk("R3 lo readback", d, 32'hA5A5_1234);
    wr(5'h0C, 32'h0F0F_F0F0); rd(5'h0C, d, d12); chk("R3 hi readback", d, 32'h0F0F_F0F0);

    // R9: absent pins read zero on the 12-pin port
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d, d12); chk("R9 mask 12 pins", d12, 32'h0000_0FFF);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d, d12); chk("R9 type_hi 12 pins", d12, 0);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d, d12); chk("R9 type_lo 12 pins", d12, 32'h00FF_FFFF);
    wr(5'h08, 0);

    // R7: disabled port ignores active levels
    wr(5'h10, 0); wr(5'h0C, 0);
    pins = 32'hFFFF_FFFF; idle(8);
    rd(5'h04, d, d12); chk("R7 no pend while off", d, 0);
    wr(5'h00, 32'h6); idle(3);
    rd(5'h04, d, d12); chk("R7 pend once enabled", d, 32'hFFFF_FFFF);
    rd(5'h04, d, d12); chk("R9 pend 12 pins", d12, 32'h0000_0FFF);

    // R2/R4: each trigger type on pins 0..3, pin 16 falling via hi word
    pins = 32'h0001_000A;
    wr(5'h10, 32'h0000_004E); wr(5'h0C, 32'h0000_0003);
    idle(5); wr(5'h04, 32'hFFFF_FFFF); idle(2);
    rd(5'h04, d, d12); chk("R2 idle inputs no event", d, 0);
    pins = 32'h0000_0005; idle(6);
    rd(5'h04, d, d12); chk("R2 all four types fire", d, 32'h0001_000F);
    pins = 32'h0001_000A; idle(6);
    rd(5'h04, d, d12); chk("R4 edges stay pending", d, 32'h0001_000F);
    wr(5'h04, 32'hFFFF_FFFF); idle(2);
    rd(5'h04, d, d12); chk("R4 clear leaves none", d, 0);
    pins = 32'h0001_000E; idle(5);
    wr(5'h04, 32'h0000_0004); idle(1);
    rd(5'h04, d, d12); chk("R4 level re-pends", d, 32'h0000_0004);

    // R5/R6: mask, irq and port flag
    rd(5'h00, d, d12); chk("R6 flag clear with mask 0", d, 32'h6);
    chk("R5 irq low mask 0", {31'd0, irq}, 0);
    wr(5'h08, 32'h0000_0004); idle(2);
    chk("R5 irq high", {31'd0, irq}, 1);
    rd(5'h00, d, d12); chk("R6 flag set", d, 32'h7);
    wr(5'h00, 32'h7); rd(5'h00, d, d12); chk("R8 flag set wins", d, 32'h7);
    wr(5'h08, 0); wr(5'h00, 32'h7); idle(1);
    rd(5'h00, d, d12); chk("R6 flag w1c", d, 32'h6);
    chk("R5 irq follows mask", {31'd0, irq}, 0);
    wr(5'h08, 32'h4); wr(5'h00, 32'h4); idle(2);
    chk("R5 irq gated by enable", {31'd0, irq}, 0);
    wr(5'h00, 32'h6); wr(5'h08, 0);

    // R8: edge arrives on the same clock as its clear
    wr(5'h10, 32'h0000_0002); wr(5'h0C, 0);
    pins = 32'h0; idle(5); wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'h1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 5'h04; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    rd(5'h04, d, d12); chk("R8 event beats clear", d, 32'h1);

    // R10: slow sampling still captures a held edge
    wr(5'h00, 32'h2); pins = 32'h0; idle(8); wr(5'h04, 32'hFFFF_FFFF);
    pins = 32'h1; idle(SLOW_DIV + 5);
    rd(5'h04, d, d12); chk("R10 slow edge", d, 32'h1);
    wr(5'h00, 32'h6);

    // R2/R4/R5: random trigger patterns
    for (int it = 0; it < 40; it++) begin
      lo = $urandom; hi = $urandom; o = $urandom; n = $urandom; m = $urandom;
      wr(5'h08, 0);
      wr(5'h10, lo); wr(5'h0C, hi);
      pins = o; idle(5);
      wr(5'h04, 32'hFFFF_FFFF); idle(3);
      pins = n; idle(6);
      e = exp_pend(lo, hi, o, n);
      rd(5'h04, d, d12); chk("R2 random pend", d, e);
      wr(5'h08, m); idle(2);
      chk("R5 random irq", {31'd0, irq}, {31'd0, |(e & m)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule